// File: doc/BRIEF.md
# Deskewed Multichannel Serial Converter Capture and Byte Packer

This block reads nine serial-output 10-bit converters that share the system clock as their bit clock. A common frame timer ticks once every `frame_period` clocks. On each tick, every enabled channel waits for its own programmed delay and then pulls its active-low start/select line low for sixteen clocks. During that window it shifts in the converter's data line, most significant bit first. The per-channel delay has one-clock resolution, so head tracks that reach the converters at different times can be realigned before their samples are combined.

The samples of one frame form a set. A set is passed through a rate reducer, which either keeps one set out of every N or replaces each channel's value with the average of N consecutive samples. The surviving set is serialised onto an 8-bit valid/ready stream, two bytes per channel, in ascending channel order, ready for a downstream FIFO. Channels cleared in the enable mask get no start pulses and take no place in the stream. A sticky flag reports sets that were dropped because the previous set was still being sent.

Top module: `trk_adc_packer`

## Requirements
- R1: While `cap_en` is high, ticks occur at cycle 0 of the run (the first cycle with `cap_en` high) and then every `frame_period` cycles. For an enabled channel with delay d, `adc_cs_n` is low for exactly 16 consecutive cycles, starting d+1 cycles after each tick. One cycle after `cap_en` is low, every `adc_cs_n` is high.
- R2: Within a frame, the serial bit sampled during the first low cycle is frame bit 15, and the later cycles carry bits 14 down to 0. The sample value is frame bits 13:4; bits 15:14 and 3:0 do not affect the output.
- R3: If a set becomes ready while the previous set is still being sent, and this is not the cycle in which its last byte is accepted, the new set is discarded whole and `ovf` goes high one cycle later. `ovf` stays high while `cap_en` is high and clears one cycle after `cap_en` is low.
- R4: Each sample is sent as two bytes. The first byte carries the channel number (1 to 9) in bits 7:4, zeros in bits 3:2 and sample bits 9:8 in bits 1:0. The second byte carries sample bits 7:0.
- R5: Within a set, channels are sent in ascending order. A channel whose `ch_mask` bit is 0 never drives its `adc_cs_n` low and is skipped in the stream.
- R6: With `red_avg`=0 and N = 2^`red_log2` (N = 1, 2, 4 or 8), only the N-th set of every group of N consecutive sets is sent, with its own values.
- R7: With `red_avg`=1, the value sent for each channel is the floor of the sum of its last N samples divided by N, and it is sent once per group of N sets.
- R8: The samples of a frame become a set at the next tick, so the first byte of a run is valid one cycle after the second tick.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold. If a new set arrives in the same cycle as the acceptance of the last byte, the new set is loaded and no overflow is raised.
- R10: After reset, every `adc_cs_n` is high, `out_valid` is low and `ovf` is low.
- R11: When `ch_mask` is all zero, no byte is ever presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the converters' bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture run enable |
| frame_period | input | 8 | Clocks between frame ticks (at least max delay + 17) |
| ch_mask | input | 9 | Per-channel enable, bit i is channel i+1 |
| ch_delay | input | 36 | Four-bit start delay per channel, channel i at bits 4i+3:4i |
| red_avg | input | 1 | 0 keeps one set in N, 1 averages N sets |
| red_log2 | input | 2 | log2 of the reduction factor N |
| adc_sdo | input | 9 | Serial data line of each converter |
| adc_cs_n | output | 9 | Active-low start/select of each converter |
| out_data | output | 8 | Packed output byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| ovf | output | 1 | Sticky dropped-set flag |

## Verification
Two functions can fall in the same cycle: accepting the final byte of a pending set, and a new set arriving at a frame tick. The bench provokes this on purpose with a single enabled channel. The ready line is raised only in the cycle before a tick and in the tick cycle itself, so the last byte always leaves exactly as the next set arrives. The reference model treats that case as a free buffer. Any overflow flag or missing set is reported, and the bench also confirms that the coinciding case actually happened.

// File: rtl/trk_pkg.sv
package trk_pkg;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_WAIT = 2'd1,
    CH_CONV = 2'd2
  } chan_st_e;

  typedef enum logic {
    RED_DROP = 1'b0,
    RED_AVG  = 1'b1
  } red_mode_e;

endpackage

// File: rtl/trk_tick_gen.sv
module trk_tick_gen #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             tick
);

  logic [PER_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == '0);
    cnt_d = cnt_q;
    if (!run)                          cnt_d = '0;
    else if (cnt_q == period - 1'b1)   cnt_d = '0;
    else                               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/trk_adc_chan.sv
module trk_adc_chan
  import trk_pkg::*;
#(
  parameter int DLY_W   = 4,
  parameter int SW      = 10,
  parameter int FRM     = 16,
  parameter int MSB_POS = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             enable,
  input  logic [DLY_W-1:0] delay,
  input  logic             sdo,
  output logic             cs_n,
  output logic [SW-1:0]    sample
);

  localparam int BW = $clog2(FRM);

  chan_st_e             st_q, st_d;
  logic [DLY_W-1:0]     wcnt_q, wcnt_d;
  logic [BW-1:0]        bcnt_q, bcnt_d;
  logic [MSB_POS-1:0]   sh_q, sh_d;
  logic [SW-1:0]        smp_q, smp_d;

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    bcnt_d = bcnt_q;
    sh_d   = sh_q;
    smp_d  = smp_q;
    if (!run) begin
      st_d = CH_IDLE;
    end else begin
      case (st_q)
        CH_IDLE: begin
          if (tick && enable) begin
            bcnt_d = '0;
            if (delay == '0) begin
              st_d = CH_CONV;
            end else begin
              st_d   = CH_WAIT;
              wcnt_d = delay - 1'b1;
            end
          end
        end
        CH_WAIT: begin
          if (wcnt_q == '0) st_d = CH_CONV;
          else              wcnt_d = wcnt_q - 1'b1;
        end
        CH_CONV: begin
          sh_d   = {sh_q[MSB_POS-2:0], sdo};
          bcnt_d = bcnt_q + 1'b1;
          if (bcnt_q == BW'(FRM-1)) begin
            st_d  = CH_IDLE;
            smp_d = sh_q[MSB_POS-1 -: SW];
          end
        end
        default: st_d = CH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_IDLE;
      wcnt_q <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
      smp_q  <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
      smp_q  <= smp_d;
    end
  end

  assign cs_n   = (st_q != CH_CONV);
  assign sample = smp_q;

endmodule

// File: rtl/trk_decim.sv
module trk_decim
  import trk_pkg::*;
#(
  parameter int NCH  = 9,
  parameter int SW   = 10,
  parameter int LG_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  red_mode_e         mode,
  input  logic [LG_W-1:0]   lg,
  input  logic [NCH*SW-1:0] smp_in,
  output logic              set_vld,
  output logic [NCH*SW-1:0] set_out
);

  localparam int CNT_W = (1 << LG_W) - 1;
  localparam int ACC_W = SW + CNT_W;

  logic             have_q, have_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lastn;
  logic             step;

  always_comb begin
    lastn   = ~({CNT_W{1'b1}} << lg);
    step    = tick && have_q;
    set_vld = step && (cnt_q == lastn);
    have_d  = have_q;
    cnt_d   = cnt_q;
    if (!run) begin
      have_d = 1'b0;
      cnt_d  = '0;
    end else if (tick) begin
      if (!have_q)      have_d = 1'b1;
      else if (set_vld) cnt_d  = '0;
      else              cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      have_q <= have_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_acc
    logic [ACC_W-1:0] acc_q, acc_d, sum;
    logic [SW-1:0]    smp;

    always_comb begin
      smp   = smp_in[g*SW +: SW];
      sum   = ((cnt_q == '0) ? '0 : acc_q) + ACC_W'(smp);
      acc_d = step ? sum : acc_q;
      set_out[g*SW +: SW] = (mode == RED_AVG) ? SW'(sum >> lg) : smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/trk_packer.sv
module trk_packer #(
  parameter int NCH = 9,
  parameter int SW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              set_vld,
  input  logic [NCH*SW-1:0] set_in,
  input  logic [NCH-1:0]    mask,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              ovf
);

  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int NUM_W = 4;
  localparam int PAD_W = 8 - NUM_W - (SW - 8);

  logic [NCH*SW-1:0] buf_q, buf_d;
  logic [NCH-1:0]    msk_q, msk_d;
  logic [IDX_W-1:0]  idx_q, idx_d, nxt_idx, first_idx;
  logic              lo_q, lo_d, pend_q, pend_d, ovf_q, ovf_d;
  logic              nxt_found, fire, last, load, drop;
  logic [SW-1:0]     cur;

  always_comb begin
    nxt_found = 1'b0;
    nxt_idx   = '0;
    first_idx = '0;
    cur       = '0;
    for (int j = NCH - 1; j >= 0; j--) begin
      if (msk_q[j] && (IDX_W'(j) > idx_q)) begin
        nxt_found = 1'b1;
        nxt_idx   = IDX_W'(j);
      end
      if (mask[j]) first_idx = IDX_W'(j);
      if (idx_q == IDX_W'(j)) cur = buf_q[j*SW +: SW];
    end
  end

  always_comb begin
    fire  = pend_q && out_ready;
    last  = fire && lo_q && !nxt_found;
    load  = set_vld && (|mask) && (!pend_q || last);
    drop  = set_vld && (|mask) && pend_q && !last;
    buf_d  = buf_q;
    msk_d  = msk_q;
    idx_d  = idx_q;
    lo_d   = lo_q;
    pend_d = pend_q;
    if (fire) begin
      if (!lo_q) begin
        lo_d = 1'b1;
      end else begin
        lo_d = 1'b0;
        if (nxt_found) idx_d  = nxt_idx;
        else           pend_d = 1'b0;
      end
    end
    if (load) begin
      buf_d  = set_in;
      msk_d  = mask;
      idx_d  = first_idx;
      lo_d   = 1'b0;
      pend_d = 1'b1;
    end
    if (!run)      ovf_d = 1'b0;
    else if (drop) ovf_d = 1'b1;
    else           ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      msk_q  <= '0;
      idx_q  <= '0;
      lo_q   <= 1'b0;
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      msk_q  <= msk_d;
      idx_q  <= idx_d;
      lo_q   <= lo_d;
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  assign out_valid = pend_q;
  assign out_data  = lo_q ? cur[7:0]
                          : {NUM_W'(idx_q) + NUM_W'(1), {PAD_W{1'b0}}, cur[SW-1:8]};
  assign ovf       = ovf_q;

endmodule

// File: rtl/trk_adc_packer.sv
module trk_adc_packer
  import trk_pkg::*;
#(
  parameter int NCH     = 9,
  parameter int SW      = 10,
  parameter int DLY_W   = 4,
  parameter int PER_W   = 8,
  parameter int FRM     = 16,
  parameter int MSB_POS = 13,
  parameter int LG_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_en,
  input  logic [PER_W-1:0]     frame_period,
  input  logic [NCH-1:0]       ch_mask,
  input  logic [NCH*DLY_W-1:0] ch_delay,
  input  logic                 red_avg,
  input  logic [LG_W-1:0]      red_log2,
  input  logic [NCH-1:0]       adc_sdo,
  output logic [NCH-1:0]       adc_cs_n,
  output logic [7:0]           out_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 ovf
);

  logic [1:0]        rs_q;
  logic              rst_i_n;
  logic              tick;
  logic [NCH*SW-1:0] smp_flat, set_flat;
  logic              set_vld;
  red_mode_e         mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];
  assign mode    = red_mode_e'(red_avg);

  trk_tick_gen #(.PER_W(PER_W)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .run(cap_en), .period(frame_period), .tick(tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    trk_adc_chan #(.DLY_W(DLY_W), .SW(SW), .FRM(FRM), .MSB_POS(MSB_POS)) u_chan (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .run    (cap_en),
      .tick   (tick),
      .enable (ch_mask[g]),
      .delay  (ch_delay[g*DLY_W +: DLY_W]),
      .sdo    (adc_sdo[g]),
      .cs_n   (adc_cs_n[g]),
      .sample (smp_flat[g*SW +: SW])
    );
  end

  trk_decim #(.NCH(NCH), .SW(SW), .LG_W(LG_W)) u_decim (
    .clk(clk), .rst_n(rst_i_n), .run(cap_en), .tick(tick), .mode(mode),
    .lg(red_log2), .smp_in(smp_flat), .set_vld(set_vld), .set_out(set_flat)
  );

  trk_packer #(.NCH(NCH), .SW(SW)) u_pack (
    .clk(clk), .rst_n(rst_i_n), .run(cap_en), .set_vld(set_vld), .set_in(set_flat),
    .mask(ch_mask), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .ovf(ovf)
  );

endmodule

// File: rtl/trk_adc_packer_chk.sv
module trk_adc_packer_chk #(
  parameter int NCH = 9,
  parameter int FRM = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cap_en,
  input logic [NCH-1:0] ch_mask,
  input logic [NCH-1:0] adc_cs_n,
  input logic [7:0]     out_data,
  input logic           out_valid,
  input logic           out_ready,
  input logic           ovf
);

  assert_cs_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> (&adc_cs_n));

  for (genvar g = 0; g < NCH; g++) begin : g_len
    logic [5:0] low_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           low_q <= '0;
      else if (!adc_cs_n[g]) low_q <= low_q + 1'b1;
      else                  low_q <= '0;
    end
    assert_cs_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      low_q <= 6'(FRM));
  end

  assert_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && $past(cap_en)) |-> ((~adc_cs_n & ~ch_mask) == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(out_valid));

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && cap_en) |=> ovf);

endmodule

bind trk_adc_packer trk_adc_packer_chk #(.NCH(NCH), .FRM(FRM)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .ch_mask(ch_mask),
  .adc_cs_n(adc_cs_n), .out_data(out_data), .out_valid(out_valid),
  .out_ready(out_ready), .ovf(ovf)
);

// File: tb/trk_adc_packer_bench.sv
module trk_adc_packer_bench;

  logic        clk;
  logic        rst_n;
  logic        cap_en;
  logic [7:0]  frame_period;
  logic [8:0]  ch_mask;
  logic [35:0] ch_delay;
  logic        red_avg;
  logic [1:0]  red_log2;
  logic [8:0]  adc_sdo;
  logic [8:0]  adc_cs_n;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready;
  logic        ovf;

  int nchk, nerr, seed, rmode, fv_k, coin, wd;
  bit go;
  string tag;
  logic [7:0] q[$];
  logic [15:0] lf;

  trk_adc_packer u_trk_adc_packer (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .frame_period(frame_period),
    .ch_mask(ch_mask), .ch_delay(ch_delay), .red_avg(red_avg), .red_log2(red_log2),
    .adc_sdo(adc_sdo), .adc_cs_n(adc_cs_n), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .ovf(ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int sval(int ch, int m);
    return (ch * 97 + m * 211 + seed * 37 + m * m * 13) % 1024;
  endfunction

  // Frame word: bits 15:14 = 2'b10, bits 13:4 sample, bits 3:0 = 4'b0101
  function automatic logic [15:0] fword(int ch, int m);
    logic [9:0] v;
    v = 10'(sval(ch, m));
    return {2'b10, v, 4'b0101};
  endfunction

  // Reference model, evaluated once per cycle away from the active edge
  int  k_prev, lc[9], fr[9], dcnt, sums[9], vals[9];
  bit  en_prev, exp_ovf;
  always @(negedge clk) begin
    int kn, kc, b, P, L;
    bit r, tk, emit, last, el;
    logic [15:0] w;
    if (go) begin
      wd++;
      if (wd > 150000) begin
        chk(0, "watchdog expired", wd, 150000);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
      end
      P  = int'(frame_period);
      L  = int'(red_log2);
      kn = cap_en ? (en_prev ? k_prev + 1 : 0) : -1;
      kc = en_prev ? k_prev + 1 : -1;
      if (kn == 0) begin
        for (int i = 0; i < 9; i++) begin lc[i] = 0; fr[i] = 0; end
        dcnt = 0;
      end
      // R1 / R5: start line timing per channel
      for (int i = 0; i < 9; i++) begin
        b  = kc - 1 - int'(ch_delay[i*4 +: 4]);
        el = (kc >= 0) && ch_mask[i] && (b >= 0) && ((b % P) < 16);
        chk(adc_cs_n[i] == !el, $sformatf("R1 R5 cs_n ch%0d", i + 1), adc_cs_n[i], !el);
      end
      // converter serial model, R2 bit order
      for (int i = 0; i < 9; i++) begin
        if (!adc_cs_n[i]) begin
          w = fword(i, fr[i]);
          adc_sdo[i] = w[15 - lc[i]];
          lc[i]++;
          if (lc[i] == 16) begin lc[i] = 0; fr[i]++; end
        end else begin
          lc[i] = 0;
          adc_sdo[i] = 1'b0;
        end
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (rmode)
        0: r = 1'b1;
        1: r = lf[0] | lf[3];
        2: r = 1'b0;
        default: r = (kn >= 0) && ((kn % P == P - 1) || (kn % P == 0));
      endcase
      out_ready = r;
      // output comparison
      chk(out_valid == (q.size() > 0), {tag, " R9 valid"}, out_valid, q.size() > 0);
      if (out_valid && q.size() > 0)
        chk(out_data == q[0], {tag, " data"}, out_data, q[0]);
      chk(ovf == exp_ovf, "R3 ovf", ovf, exp_ovf);
      if (out_valid && fv_k < 0) fv_k = kc;
      last = 1'b0;
      if (q.size() > 0 && r) begin
        void'(q.pop_front());
        last = (q.size() == 0);
      end
      tk = (kn >= 0) && (kn % P == 0);
      emit = 1'b0;
      if (tk && kn > 0) begin
        if (dcnt == 0) for (int i = 0; i < 9; i++) sums[i] = 0;
        for (int i = 0; i < 9; i++) sums[i] += sval(i, kn / P - 1);
        dcnt++;
        if (dcnt == (1 << L)) begin
          emit = 1'b1;
          dcnt = 0;
          for (int i = 0; i < 9; i++)
            vals[i] = red_avg ? (sums[i] >> L) : sval(i, kn / P - 1);
        end
      end
      if (emit && ch_mask != '0) begin
        if (q.size() == 0) begin
          if (last) coin++;
          for (int i = 0; i < 9; i++) begin
            if (ch_mask[i]) begin
              q.push_back({4'(i + 1), 2'b00, 2'(vals[i] >> 8)});
              q.push_back(8'(vals[i]));
            end
          end
        end else begin
          exp_ovf = 1'b1;
        end
      end
      if (!cap_en) exp_ovf = 1'b0;
      en_prev = cap_en;
      k_prev  = kn;
    end
  end

  task automatic start_run(input int P, input logic [8:0] m, input logic [35:0] d,
                           input logic avg, input logic [1:0] lg, input int rm,
                           input int sd, input string t);
    @(posedge clk); #1;
    frame_period = 8'(P);
    ch_mask = m; ch_delay = d; red_avg = avg; red_log2 = lg;
    rmode = rm; seed = sd; tag = t; fv_k = -1;
    cap_en = 1'b1;
  endtask

  task automatic stop_run();
    @(posedge clk); #1;
    cap_en = 1'b0;
    rmode = 0;
    repeat (60) @(posedge clk);
    #1;
    chk(q.size() == 0, {tag, " stream drained"}, q.size(), 0);
  endtask

  initial begin
    logic [35:0] dl;
    rst_n = 1'b0; cap_en = 1'b0; go = 1'b0; rmode = 0; out_ready = 1'b0;
    adc_sdo = '0; frame_period = 8'd34; ch_mask = '1; ch_delay = '0;
    red_avg = 1'b0; red_log2 = 2'd0; seed = 1; tag = "R10";
    nchk = 0; nerr = 0; coin = 0; wd = 0; fv_k = -1; lf = 16'hACE1;
    k_prev = -1; en_prev = 1'b0; exp_ovf = 1'b0; dcnt = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(adc_cs_n == 9'h1FF, "R10 reset cs_n", adc_cs_n, 9'h1FF);
    chk(out_valid == 1'b0, "R10 reset out_valid", out_valid, 0);
    chk(ovf == 1'b0, "R10 reset ovf", ovf, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1 go = 1'b1;

    // R2 R4 R5 R8: all channels, delay = channel index, keep every set
    for (int i = 0; i < 9; i++) dl[i*4 +: 4] = 4'(i);
    start_run(34, 9'h1FF, dl, 1'b0, 2'd0, 0, 1, "R2 R4 R5");
    repeat (340) @(posedge clk);
    chk(fv_k == 35, "R8 first byte cycle", fv_k, 35);
    stop_run();

    // R7 R5: sparse mask, mixed delays, average of 4, irregular ready
    for (int i = 0; i < 9; i++) dl[i*4 +: 4] = (i % 2 == 0) ? 4'd15 : 4'(i);
    start_run(40, 9'b101010101, dl, 1'b1, 2'd2, 1, 2, "R7 R5");
    repeat (560) @(posedge clk);
    stop_run();

    // R6: keep one set of two, irregular ready
    start_run(34, 9'h1FF, 36'h0123456789, 1'b0, 2'd1, 1, 3, "R6");
    repeat (408) @(posedge clk);
    stop_run();

    // R7: average of 8 with maximum delay everywhere
    start_run(32, 9'h1FF, {9{4'hF}}, 1'b1, 2'd3, 0, 4, "R7");
    repeat (640) @(posedge clk);
    stop_run();

    // R3: stalled consumer forces dropped sets
    start_run(34, 9'h1FF, 36'h0, 1'b0, 2'd0, 2, 5, "R3");
    repeat (136) @(posedge clk);
    #1 chk(ovf == 1'b1, "R3 overflow raised", ovf, 1);
    rmode = 0;
    repeat (102) @(posedge clk);
    #1 chk(ovf == 1'b1, "R3 overflow sticky", ovf, 1);
    stop_run();
    chk(ovf == 1'b0, "R3 overflow cleared", ovf, 0);

    // R9: last-byte acceptance coincides with the next set
    start_run(20, 9'b000010000, 36'h0000_3_0000, 1'b0, 2'd0, 3, 6, "R9");
    repeat (240) @(posedge clk);
    stop_run();
    chk(coin > 0, "R9 coincidence exercised", coin, 1);

    // R11: nothing enabled, nothing emitted
    start_run(34, 9'h000, 36'h0, 1'b0, 2'd0, 0, 7, "R11");
    repeat (136) @(posedge clk);
    chk(fv_k < 0, "R11 no output", fv_k, -1);
    stop_run();

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule